// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-on to a usable state. After reset it holds the command bus at NOP with the clock enable high for a programmable stabilisation interval. It then closes every bank with a precharge-all and issues two auto-refresh commands. Last, it writes the mode register with a word built from the burst length, burst type, CAS latency and write-burst fields on its inputs. After each command it leaves a NOP gap sized to the matching device timing parameter. When the final wait has elapsed it raises a done flag, and the memory controller can then start normal traffic.

Every interval is given in nanoseconds together with the clock frequency in MHz. Each one is converted to whole clock cycles by rounding up, with a minimum of one cycle. If the requested mode fields hold a reserved code, the sequencer does not load the mode register. It parks on NOP and raises an error flag instead. Reset is asynchronous, active low, and released synchronously inside the block.

Top module: `sdram_init_seq`

## Requirements
- R1: The clock-enable output is high at all times, including during reset.
- R2: During reset and after its release, the command bus carries only NOP (chip-select, row, column, write strobes = 0111) for at least N_PWR = ceil(PWRUP_NS*CLK_MHZ/1000) cycles (minimum 1) before any other command.
- R3: The first command other than NOP is PRECHARGE (0010) with address 12'h400 (bit 10 high, selecting all banks) and bank address 00.
- R4: The first AUTO REFRESH (0001) appears exactly N_RP = ceil(TRP_NS*CLK_MHZ/1000) cycles after the PRECHARGE, with only NOP in between.
- R5: Exactly two AUTO REFRESH commands are issued. The second follows the first by exactly N_RC = ceil(TRC_NS*CLK_MHZ/1000) cycles.
- R6: With legal fields, LOAD MODE REGISTER (0000) appears exactly N_RC cycles after the second refresh. Bank address is 00 and the address is {2'b00, write_single, 2'b00, cas_lat[2:0], burst_type, burst_len[2:0]}, with bit 0 the least significant.
- R7: A field set is legal when the CAS latency is 010 or 011 and the burst length is 000..011, or 111 with burst type 0. Any other field set is illegal. With illegal fields no LOAD MODE REGISTER is issued. The error flag rises exactly N_RC cycles after the second refresh and stays high, with only NOP thereafter.
- R8: The done flag rises exactly N_MRD = ceil(TMRD_NS*CLK_MHZ/1000) cycles after LOAD MODE REGISTER. It then stays high until reset, and only NOP follows.
- R9: Done and error are low during reset and during the sequence, and are never both high. Asserting reset at any point clears both flags at once and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_len_i | input | 3 | Burst length code |
| burst_type_i | input | 1 | Burst type, 0 sequential, 1 interleaved |
| cas_lat_i | input | 3 | CAS latency code |
| wr_single_i | input | 1 | Write burst mode, 1 = single-location writes |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | 12 | Address bus |
| ba_o | output | 2 | Bank address |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | Reserved mode field detected |

## Verification
The bench measures the exact cycle distance between successive commands. A sequencer off by one in any wait would put a refresh or the mode load one cycle early or late. The bench uses a mode-register wait of one cycle, which a design must handle by skipping its wait state; a naive counter would either underflow or stall there. Directed cases cover the full-page length with both burst types, since interleaved full page is reserved, plus reserved CAS and length codes. A design with a loose legality check would load the mode register where it should raise the error flag. A reset asserted after done checks that the flags clear and the power-up wait is repeated, not skipped.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_PRE, ST_TRP, ST_REF1, ST_TRC1,
    ST_REF2, ST_TRC2, ST_LMR, ST_TMRD, ST_DONE, ST_ERR
  } st_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_rst_sync.sv
module init_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == W'(1));

  // R4
  cnt_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/init_mode_word.sv
module init_mode_word (
  input  logic [2:0]  burst_len_i,
  input  logic        burst_type_i,
  input  logic [2:0]  cas_lat_i,
  input  logic        wr_single_i,
  output logic [11:0] word_o,
  output logic        legal_o
);
  logic cas_ok, len_ok;

  assign cas_ok  = (cas_lat_i == 3'b010) || (cas_lat_i == 3'b011);
  assign len_ok  = !burst_len_i[2] || ((burst_len_i == 3'b111) && !burst_type_i);
  assign legal_o = cas_ok && len_ok;

  assign word_o = {2'b00, wr_single_i, 2'b00, cas_lat_i, burst_type_i, burst_len_i};
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned PWRUP_NS  = 100000,
  parameter int unsigned TRP_NS    = 20,
  parameter int unsigned TRC_NS    = 70,
  parameter int unsigned TMRD_NS   = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  burst_len_i,
  input  logic        burst_type_i,
  input  logic [2:0]  cas_lat_i,
  input  logic        wr_single_i,
  output logic        cke_o,
  output logic        cs_n_o,
  output logic        ras_n_o,
  output logic        cas_n_o,
  output logic        we_n_o,
  output logic [11:0] addr_o,
  output logic [1:0]  ba_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int unsigned N_PWR = ns_to_cyc(PWRUP_NS, CLK_MHZ);
  localparam int unsigned N_RP  = ns_to_cyc(TRP_NS, CLK_MHZ);
  localparam int unsigned N_RC  = ns_to_cyc(TRC_NS, CLK_MHZ);
  localparam int unsigned N_MRD = ns_to_cyc(TMRD_NS, CLK_MHZ);
  localparam int unsigned N_MAX = umax(umax(N_PWR, N_RP), umax(N_RC, N_MRD));
  localparam int unsigned CW    = $clog2(N_MAX + 1);
  localparam logic RP_WAIT  = (N_RP  > 1);
  localparam logic RC_WAIT  = (N_RC  > 1);
  localparam logic MRD_WAIT = (N_MRD > 1);

  logic          rst_sync_n;
  st_e           st_q, st_d;
  cmd_e          cmd_d;
  logic [3:0]    cmd_q;
  logic [11:0]   addr_d, addr_q;
  logic          done_q, err_q, cke_q;
  logic          tmr_load, tmr_dec, tmr_last;
  logic [CW-1:0] tmr_val;
  logic [11:0]   mode_word;
  logic          mode_legal;

  init_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  init_wait_timer #(.W(CW), .RST_VAL(N_PWR)) i_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .last_o     (tmr_last)
  );

  init_mode_word i_mode (
    .burst_len_i  (burst_len_i),
    .burst_type_i (burst_type_i),
    .cas_lat_i    (cas_lat_i),
    .wr_single_i  (wr_single_i),
    .word_o       (mode_word),
    .legal_o      (mode_legal)
  );

  // Next-state and command decode
  always_comb begin
    st_d     = st_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_PWR: begin
        tmr_dec = 1'b1;
        if (tmr_last) st_d = ST_PRE;
      end
      ST_PRE: begin
        cmd_d      = CMD_PRE;
        addr_d[10] = 1'b1;
        tmr_val    = CW'(N_RP - 1);
        tmr_load   = RP_WAIT;
        st_d       = RP_WAIT ? ST_TRP : ST_REF1;
      end
      ST_TRP: begin
        tmr_dec = 1'b1;
        if (tmr_last) st_d = ST_REF1;
      end
      ST_REF1: begin
        cmd_d    = CMD_REF;
        tmr_val  = CW'(N_RC - 1);
        tmr_load = RC_WAIT;
        st_d     = RC_WAIT ? ST_TRC1 : ST_REF2;
      end
      ST_TRC1: begin
        tmr_dec = 1'b1;
        if (tmr_last) st_d = ST_REF2;
      end
      ST_REF2: begin
        cmd_d    = CMD_REF;
        tmr_val  = CW'(N_RC - 1);
        tmr_load = RC_WAIT;
        if (RC_WAIT)         st_d = ST_TRC2;
        else if (mode_legal) st_d = ST_LMR;
        else                 st_d = ST_ERR;
      end
      ST_TRC2: begin
        tmr_dec = 1'b1;
        if (tmr_last) st_d = mode_legal ? ST_LMR : ST_ERR;
      end
      ST_LMR: begin
        cmd_d    = CMD_LMR;
        addr_d   = mode_word;
        tmr_val  = CW'(N_MRD - 1);
        tmr_load = MRD_WAIT;
        st_d     = MRD_WAIT ? ST_TMRD : ST_DONE;
      end
      ST_TMRD: begin
        tmr_dec = 1'b1;
        if (tmr_last) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_DONE;
      ST_ERR:  st_d = ST_ERR;
      default: st_d = ST_ERR;
    endcase
  end

  // State and output registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_PWR;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cke_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      done_q <= (st_q == ST_DONE);
      err_q  <= (st_q == ST_ERR);
      cke_q  <= 1'b1;
    end
  end

  assign cke_o   = cke_q;
  assign cs_n_o  = cmd_q[3];
  assign ras_n_o = cmd_q[2];
  assign cas_n_o = cmd_q[1];
  assign we_n_o  = cmd_q[0];
  assign addr_o  = addr_q;
  assign ba_o    = 2'b00;
  assign done_o  = done_q;
  assign err_o   = err_q;

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> done_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_o |=> err_o);

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(done_o && err_o));

  // R6
  lmr_legal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_q == CMD_LMR) |-> mode_legal);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_o |-> (cmd_q == CMD_NOP));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (cmd_q == CMD_NOP));
endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_MHZ  = 100;
  localparam int unsigned PWRUP_NS = 1500;
  localparam int unsigned TRP_NS   = 20;
  localparam int unsigned TRC_NS   = 65;
  localparam int unsigned TMRD_NS  = 10;

  function automatic int cyc(input int unsigned ns);
    int c;
    c = int'((ns * CLK_MHZ + 999) / 1000);
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_PWR = 150;
  localparam int E_RP  = 2;
  localparam int E_RC  = 7;
  localparam int E_MRD = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] bl;
  logic bt;
  logic [2:0] cl;
  logic wb;
  logic cke, cs_n, ras_n, cas_n, we_n, done, err;
  logic [11:0] addr;
  logic [1:0] ba;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_NS(PWRUP_NS), .TRP_NS(TRP_NS),
    .TRC_NS(TRC_NS), .TMRD_NS(TMRD_NS)
  ) i_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .burst_len_i(bl), .burst_type_i(bt),
    .cas_lat_i(cl), .wr_single_i(wb), .cke_o(cke), .cs_n_o(cs_n),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr),
    .ba_o(ba), .done_o(done), .err_o(err)
  );

  function automatic bit f_legal(input logic [2:0] l, input logic t, input logic [2:0] c);
    bit cok, lok;
    cok = (c == 3'd2) || (c == 3'd3);
    lok = (l <= 3'd3) || ((l == 3'd7) && (t == 1'b0));
    return cok && lok;
  endfunction

  function automatic logic [11:0] f_word(input logic [2:0] l, input logic t,
                                        input logic [2:0] c, input logic w);
    return {2'b00, w, 2'b00, c, t, l};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic run_trial(input logic [2:0] l, input logic t, input logic [2:0] c, input logic w);
    int limit;
    int nop_pre, t_pre, t_ref1, t_ref2, t_lmr, t_done, t_err, n_ref, n_lmr, n_bad;
    int after_end, cke_low, both, done_fall, err_fall;
    logic [11:0] pre_addr, lmr_addr;
    logic [1:0] pre_ba, lmr_ba;
    logic [3:0] cmd;
    bit legal;
    legal = f_legal(l, t, c);
    @(negedge clk);
    rst_n = 1'b0;
    bl = l; bt = t; cl = c; wb = w;
    repeat (3) @(negedge clk);
    // R2 R9 reset state
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111 && !done && !err, "R2/R9 reset state",
        {cs_n, ras_n, cas_n, we_n, done, err}, 6'b011100);
    chk(cke == 1'b1, "R1 cke in reset", cke, 1);
    rst_n = 1'b1;
    limit = E_PWR + E_RP + 2 * E_RC + E_MRD + 40;
    nop_pre = 0; t_pre = -1; t_ref1 = -1; t_ref2 = -1; t_lmr = -1; t_done = -1; t_err = -1;
    n_ref = 0; n_lmr = 0; n_bad = 0; after_end = 0; cke_low = 0; both = 0;
    done_fall = 0; err_fall = 0; pre_addr = '0; lmr_addr = '0; pre_ba = '0; lmr_ba = '0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      cmd = {cs_n, ras_n, cas_n, we_n};
      if (!cke) cke_low++;
      if (done && err) both++;
      if (t_done >= 0 && !done) done_fall++;
      if (t_err >= 0 && !err) err_fall++;
      if (done && t_done < 0) t_done = i;
      if (err && t_err < 0) t_err = i;
      if ((t_lmr >= 0 || t_err >= 0) && cmd != 4'b0111) after_end++;
      case (cmd)
        4'b0111: if (t_pre < 0) nop_pre++;
        4'b0010: begin
          if (t_pre < 0) begin t_pre = i; pre_addr = addr; pre_ba = ba; end
          else n_bad++;
        end
        4'b0001: begin
          n_ref++;
          if (n_ref == 1) t_ref1 = i;
          if (n_ref == 2) t_ref2 = i;
        end
        4'b0000: begin
          n_lmr++;
          if (t_lmr < 0) begin t_lmr = i; lmr_addr = addr; lmr_ba = ba; end
        end
        default: n_bad++;
      endcase
    end
    chk(cke_low == 0, "R1 cke high", cke_low, 0);
    chk(nop_pre >= E_PWR && nop_pre <= E_PWR + 3, "R2 power-up NOP count", nop_pre, E_PWR);
    chk(n_bad == 0, "R2 no stray commands", n_bad, 0);
    chk(t_pre > 0 && pre_addr == 12'h400 && pre_ba == 2'b00, "R3 precharge-all",
        {pre_ba, pre_addr}, 14'h0400);
    chk(t_ref1 - t_pre == E_RP, "R4 tRP gap", t_ref1 - t_pre, E_RP);
    chk(n_ref == 2, "R5 refresh count", n_ref, 2);
    chk(t_ref2 - t_ref1 == E_RC, "R5 tRC gap", t_ref2 - t_ref1, E_RC);
    chk(both == 0, "R9 done/err exclusive", both, 0);
    if (legal) begin
      chk(n_lmr == 1 && t_lmr - t_ref2 == E_RC, "R6 mode load timing", t_lmr - t_ref2, E_RC);
      chk(lmr_addr == f_word(l, t, c, w) && lmr_ba == 2'b00, "R6 mode word",
          {lmr_ba, lmr_addr}, {2'b00, f_word(l, t, c, w)});
      chk(t_done - t_lmr == E_MRD, "R8 done timing", t_done - t_lmr, E_MRD);
      chk(done_fall == 0 && after_end == 0, "R8 done sticky and quiet",
          done_fall + after_end, 0);
      chk(t_err < 0, "R9 no error on legal fields", t_err, -1);
    end else begin
      chk(n_lmr == 0, "R7 no mode load on reserved fields", n_lmr, 0);
      chk(t_err - t_ref2 == E_RC, "R7 error timing", t_err - t_ref2, E_RC);
      chk(err_fall == 0 && after_end == 0, "R7 error sticky and quiet",
          err_fall + after_end, 0);
      chk(t_done < 0, "R9 no done on reserved fields", t_done, -1);
    end
  endtask

  initial begin
    rst_n = 1'b0; bl = 3'd0; bt = 1'b0; cl = 3'd2; wb = 1'b0;
    void'($urandom(32'h5eed_1234));
    chk(cyc(PWRUP_NS) == E_PWR && cyc(TRC_NS) == E_RC && cyc(TMRD_NS) == E_MRD,
        "R2 cycle rounding", cyc(TRC_NS), E_RC);
    // directed corner cases
    run_trial(3'b111, 1'b0, 3'b011, 1'b1);  // full page sequential: legal
    run_trial(3'b111, 1'b1, 3'b010, 1'b0);  // full page interleaved: reserved
    run_trial(3'b000, 1'b0, 3'b001, 1'b0);  // reserved CAS
    run_trial(3'b100, 1'b1, 3'b010, 1'b0);  // reserved length
    run_trial(3'b011, 1'b1, 3'b011, 1'b1);  // legal, all fields set
    // R9 reset after done clears flags and restarts
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!done && !err && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R9 reset clears done",
        {done, err}, 0);
    // random trials
    for (int k = 0; k < 20; k++) begin
      logic [2:0] rl, rc;
      logic rt, rw;
      rl = 3'($urandom);
      rt = 1'($urandom);
      rw = 1'($urandom);
      rc = ($urandom % 10 < 7) ? (3'd2 + 3'($urandom % 2)) : 3'($urandom);
      run_trial(rl, rt, rc, rw);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule